// File: doc/BRIEF.md
# Triple Interval Timer with Match and Wrap Events

This peripheral holds three independent counters behind a simple word-addressed register bus. Each counter has four registers: the live count, a reload value and two compare values. One shared control word switches each counter on or off and sets its count direction. The same word chooses whether the counter steps on every bus clock or only on cycles where its external tick-enable input is high. It also holds a per-counter gate for the wrap interrupt.

Whenever a step takes a counter past its end value, the counter takes its reload value and raises a wrap event. The end value is all-ones when counting up and zero when counting down. A step that lands the counter on one of its compare values raises a match event. All nine events are held in a shared sticky status register, and software clears them by writing ones. A mask register and the wrap gates then filter the status into one registered interrupt line. Typical uses are a periodic tick, made by preloading the counter and reload registers with all-ones minus (period - 1) in up mode, and a one-shot deadline, made by writing the current count plus a delta into a compare register.

Top module: `triple_timer`

## Requirements
- R1: After reset every counter, reload and compare register reads 0, control reads 0, status reads 0, the mask reads 0x1FF and irq_o is 0.
- R2: addr_i is a word index, so word = byte offset / 4. Timer n (0..2) has count at word 4n, reload at 4n+1, compare 1 at 4n+2 and compare 2 at 4n+3. Control is at word 12, status at 13 and mask at 14. rdata_o carries the addressed register one cycle after a read request and holds it until the next read.
- R3: Control bit 3n enables timer n, and bit 9+n set selects up counting. In up mode an enabled step adds 1, and a step taken at 0xFFFFFFFF loads the reload value and raises the wrap event, which is status bit 3n+2.
- R4: With bit 9+n clear the counter counts down. A step taken at 0 loads the reload value and raises the wrap event.
- R5: A step whose new counter value equals compare 1 sets status bit 3n. A step whose new value equals compare 2 sets status bit 3n+1.
- R6: With the enable bit clear the counter holds its value. Setting the enable again resumes counting from that value.
- R7: When control bit 3n+1 is set, timer n steps only in cycles where tick_i[n] is 1.
- R8: A bus write to a counter in the same cycle as a step takes priority. The next step then continues from the written value.
- R9: Status bits are sticky. Writing 1 to a bit clears it, and writing 0 has no effect. An event in the same cycle as a clear leaves the bit set.
- R10: irq_o is the registered OR of status AND NOT mask. Each wrap bit additionally needs control bit 3n+2 set.
- R11: Unimplemented control bits (above 11), status and mask bits (above 8), and words above 14 read as 0. Writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and count clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 3 | Per-timer step enable, used when the timer's clock select bit is set |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
The hardest conditions to reach are a wrap that meets a compare value and a counter write that collides with a step. Both need the counter to be in a known state on an exact clock edge. The stimulus gets there by preloading the counter within a few steps of its end value. It then opens the enable for a counted number of cycles through back-to-back control writes, so the number of steps is exact and the frozen result can be read back. Collisions are made by writing the counter while the timer is still enabled. The wrap-interrupt gate is exercised by leaving a wrap status pending with the gate closed and then opening the gate.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_TMR  = 3;
  localparam int DATA_W   = 32;
  localparam int EV_W     = 3 * NUM_TMR;
  localparam int CTRL_W   = 4 * NUM_TMR;
  localparam int CTRL_IDX = 12;
  localparam int STS_IDX  = 13;
  localparam int MSK_IDX  = 14;
  // per-channel register select inside a 4-word window
  typedef enum logic [1:0] {
    SEL_CNT  = 2'd0,
    SEL_LOAD = 2'd1,
    SEL_CMP1 = 2'd2,
    SEL_CMP2 = 2'd3
  } chan_sel_e;
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             ext_sel_i,
  input  logic             tick_ext_i,
  input  logic             up_i,
  input  logic [3:0]       we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] load_o,
  output logic [CNT_W-1:0] cmp1_o,
  output logic [CNT_W-1:0] cmp2_o,
  output logic [2:0]       evt_o
);
  logic [CNT_W-1:0] cnt_q, load_q, cmp1_q, cmp2_q, nxt;
  logic             step, at_end, cnt_wr;

  assign cnt_wr = we_i[tmr_pkg::SEL_CNT];
  assign step   = en_i & (ext_sel_i ? tick_ext_i : 1'b1);
  assign at_end = up_i ? (&cnt_q) : (cnt_q == '0);

  always_comb begin
    if (at_end)    nxt = load_q;
    else if (up_i) nxt = cnt_q + 1'b1;
    else           nxt = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      load_q <= '0;
      cmp1_q <= '0;
      cmp2_q <= '0;
      evt_o  <= '0;
    end else begin
      if (cnt_wr)     cnt_q <= wdata_i;
      else if (step)  cnt_q <= nxt;
      if (we_i[tmr_pkg::SEL_LOAD]) load_q <= wdata_i;
      if (we_i[tmr_pkg::SEL_CMP1]) cmp1_q <= wdata_i;
      if (we_i[tmr_pkg::SEL_CMP2]) cmp2_q <= wdata_i;
      // bit order: cmp1, cmp2, wrap
      evt_o[0] <= step & ~cnt_wr & (nxt == cmp1_q);
      evt_o[1] <= step & ~cnt_wr & (nxt == cmp2_q);
      evt_o[2] <= step & ~cnt_wr & at_end;
    end
  end

  assign cnt_o  = cnt_q;
  assign load_o = load_q;
  assign cmp1_o = cmp1_q;
  assign cmp2_o = cmp2_q;
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq
  import tmr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sts_we_i,
  input  logic               msk_we_i,
  input  logic [EV_W-1:0]    wdata_i,
  input  logic [EV_W-1:0]    evt_i,
  input  logic [NUM_TMR-1:0] wrap_ie_i,
  output logic [EV_W-1:0]    sts_o,
  output logic [EV_W-1:0]    msk_o,
  output logic               irq_o
);
  logic [EV_W-1:0] sts_q, msk_q, clr, gate;

  for (genvar n = 0; n < NUM_TMR; n++) begin : g_gate
    assign gate[3*n]   = 1'b1;
    assign gate[3*n+1] = 1'b1;
    assign gate[3*n+2] = wrap_ie_i[n];
  end

  assign clr = sts_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      msk_q <= '1;
      irq_o <= 1'b0;
    end else begin
      sts_q <= (sts_q & ~clr) | evt_i;   // set beats clear
      if (msk_we_i) msk_q <= wdata_i;
      irq_o <= |(sts_q & ~msk_q & gate);
    end
  end

  assign sts_o = sts_q;
  assign msk_o = msk_q;
endmodule

// File: rtl/triple_timer.sv
module triple_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_TMR-1:0]   tick_i,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 irq_o
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic [CTRL_W-1:0]                   ctrl_q;
  logic [NUM_TMR-1:0][CNT_W-1:0]       cnt_w, load_w, cmp1_w, cmp2_w;
  logic [EV_W-1:0]                     evt_w, sts_w, msk_w;
  logic [NUM_TMR-1:0]                  wrap_ie;
  logic                                wr, rd, in_chan;
  logic [1:0]                          chan_idx, reg_sel;
  logic [DATA_W-1:0]                   rd_nxt;

  assign wr       = req_i & we_i;
  assign rd       = req_i & ~we_i;
  assign chan_idx = addr_i[3:2];
  assign reg_sel  = addr_i[1:0];
  assign in_chan  = (addr_i < ADDR_W'(CTRL_IDX));

  for (genvar n = 0; n < NUM_TMR; n++) begin : g_chan
    logic [3:0] chan_we;
    for (genvar r = 0; r < 4; r++) begin : g_we
      assign chan_we[r] = wr & in_chan & (chan_idx == 2'(n)) & (reg_sel == 2'(r));
    end
    assign wrap_ie[n] = ctrl_q[3*n+2];

    tmr_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (ctrl_q[3*n]),
      .ext_sel_i  (ctrl_q[3*n+1]),
      .tick_ext_i (tick_i[n]),
      .up_i       (ctrl_q[3*NUM_TMR+n]),
      .we_i       (chan_we),
      .wdata_i    (wdata_i[CNT_W-1:0]),
      .cnt_o      (cnt_w[n]),
      .load_o     (load_w[n]),
      .cmp1_o     (cmp1_w[n]),
      .cmp2_o     (cmp2_w[n]),
      .evt_o      (evt_w[3*n +: 3])
    );
  end

  tmr_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sts_we_i  (wr & (addr_i == ADDR_W'(STS_IDX))),
    .msk_we_i  (wr & (addr_i == ADDR_W'(MSK_IDX))),
    .wdata_i   (wdata_i[EV_W-1:0]),
    .evt_i     (evt_w),
    .wrap_ie_i (wrap_ie),
    .sts_o     (sts_w),
    .msk_o     (msk_w),
    .irq_o     (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   ctrl_q <= '0;
    else if (wr && addr_i == ADDR_W'(CTRL_IDX))    ctrl_q <= wdata_i[CTRL_W-1:0];
  end

  always_comb begin
    rd_nxt = '0;
    if (in_chan && chan_idx < 2'(NUM_TMR)) begin
      unique case (reg_sel)
        SEL_CNT:  rd_nxt = {{PAD_W{1'b0}}, cnt_w[chan_idx]};
        SEL_LOAD: rd_nxt = {{PAD_W{1'b0}}, load_w[chan_idx]};
        SEL_CMP1: rd_nxt = {{PAD_W{1'b0}}, cmp1_w[chan_idx]};
        default:  rd_nxt = {{PAD_W{1'b0}}, cmp2_w[chan_idx]};
      endcase
    end else if (addr_i == ADDR_W'(CTRL_IDX)) begin
      rd_nxt = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
    end else if (addr_i == ADDR_W'(STS_IDX)) begin
      rd_nxt = {{(DATA_W-EV_W){1'b0}}, sts_w};
    end else if (addr_i == ADDR_W'(MSK_IDX)) begin
      rd_nxt = {{(DATA_W-EV_W){1'b0}}, msk_w};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_nxt;
  end
endmodule

// File: rtl/triple_timer_chk.sv
module triple_timer_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 6
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           req_i,
  input logic                           we_i,
  input logic [ADDR_W-1:0]              addr_i,
  input logic [DATA_W-1:0]              wdata_i,
  input logic [DATA_W-1:0]              rdata_o,
  input logic                           irq_o,
  input logic [CTRL_W-1:0]              ctrl_q,
  input logic [EV_W-1:0]                sts_w,
  input logic [EV_W-1:0]                msk_w,
  input logic [EV_W-1:0]                evt_w,
  input logic [NUM_TMR-1:0][CNT_W-1:0]  cnt_w
);
  logic sts_wr;
  assign sts_wr = req_i & we_i & (addr_i == ADDR_W'(STS_IDX));

  // R9: without a status write no set bit drops
  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sts_wr |=> ((sts_w & $past(sts_w)) == $past(sts_w)));

  // R9: a write-one clears the bit unless an event arrives alongside
  p_w1c_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_wr && evt_w == '0) |=> ((sts_w & $past(wdata_i[EV_W-1:0])) == '0));

  // R10: nothing unmasked pending -> no interrupt next cycle
  p_masked_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sts_w & ~msk_w) == '0) |=> !irq_o);

  // R11: unmapped words read as zero
  p_unmapped_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i > ADDR_W'(MSK_IDX)) |=> (rdata_o == '0));

  for (genvar n = 0; n < NUM_TMR; n++) begin : g_freeze
    // R6: disabled and not written -> count holds
    p_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ctrl_q[3*n] && !(req_i && we_i && addr_i == ADDR_W'(4*n))) |=> $stable(cnt_w[n]));
  end
endmodule

bind triple_timer triple_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .ctrl_q  (ctrl_q),
  .sts_w   (sts_w),
  .msk_w   (msk_w),
  .evt_w   (evt_w),
  .cnt_w   (cnt_w)
);

// File: tb/triple_timer_tb.sv
module triple_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  tick_i = '0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] rd_val;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  triple_timer #(.CNT_W(32), .ADDR_W(ADDR_W)) u_dut (
    .clk_i, .rst_ni, .tick_i, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o, .irq_o
  );

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = ADDR_W'(a); wdata_i = d;
    @(posedge clk_i); #1;
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input int a);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = ADDR_W'(a);
    @(posedge clk_i); #1;
    req_i = 1'b0;
    rd_val = rdata_o;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic t_reset();
    rd(0);  chk("R1 count0", rd_val, 0);
    rd(5);  chk("R1 reload1", rd_val, 0);
    rd(12); chk("R1 control", rd_val, 0);
    rd(13); chk("R1 status", rd_val, 0);
    rd(14); chk("R1 mask", rd_val, 32'h1FF);
    chk("R1 irq", {31'd0, irq_o}, 0);
  endtask

  task automatic t_up_freeze();
    wr(0, 100);
    wr(12, 32'h201);
    idle(4);
    wr(12, 0);
    rd(0); chk("R3 up count", rd_val, 105);
    idle(3);
    rd(0); chk("R6 frozen", rd_val, 105);
    wr(12, 32'h201);
    idle(1);
    wr(12, 0);
    rd(0); chk("R6 resume", rd_val, 107);
  endtask

  task automatic t_down();
    wr(4, 5);
    wr(12, 32'h008);
    idle(2);
    wr(12, 0);
    rd(4); chk("R4 down count", rd_val, 2);
  endtask

  task automatic t_up_wrap();
    wr(1, 32'h1000);
    wr(0, 32'hFFFF_FFFE);
    wr(14, 32'h1FB);
    wr(13, 32'h1FF);
    wr(12, 32'h205);
    idle(2);
    wr(12, 32'h004);
    rd(0);  chk("R3 reload after wrap", rd_val, 32'h1001);
    rd(13); chk("R3 wrap status", rd_val, 32'h004);
    idle(1);
    chk("R10 irq on wrap", {31'd0, irq_o}, 1);
    wr(13, 0);
    rd(13); chk("R9 zero write keeps", rd_val, 32'h004);
    wr(13, 32'h004);
    idle(2);
    chk("R10 irq after clear", {31'd0, irq_o}, 0);
    rd(13); chk("R9 w1c", rd_val, 0);
  endtask

  task automatic t_down_wrap_gate();
    wr(10, 32'h1234);
    wr(11, 32'h1234);
    wr(9, 32'h20);
    wr(8, 1);
    wr(14, 32'h0FF);
    wr(12, 32'h040);
    idle(1);
    wr(12, 0);
    rd(8);  chk("R4 reload after zero", rd_val, 32'h20);
    rd(13); chk("R4 wrap status", rd_val, 32'h100);
    idle(2);
    chk("R10 wrap gate closed", {31'd0, irq_o}, 0);
    wr(12, 32'h100);
    idle(2);
    chk("R10 wrap gate open", {31'd0, irq_o}, 1);
    wr(13, 32'h1FF);
    wr(12, 0);
  endtask

  task automatic t_match();
    wr(6, 32'h50);
    wr(7, 32'h52);
    wr(4, 32'h4E);
    wr(14, 32'h1F7);
    wr(12, 32'h408);
    idle(4);
    wr(12, 0);
    rd(4);  chk("R5 count", rd_val, 32'h53);
    rd(13); chk("R5 match status", rd_val, 32'h18);
    idle(1);
    chk("R10 irq on match", {31'd0, irq_o}, 1);
    wr(14, 32'h1FF);
    idle(2);
    chk("R10 masked", {31'd0, irq_o}, 0);
    wr(13, 32'h1FF);
  endtask

  task automatic t_collide();
    wr(0, 0);
    wr(12, 32'h201);
    idle(2);
    wr(0, 32'h200);
    wr(12, 0);
    rd(0); chk("R8 write wins", rd_val, 32'h201);
  endtask

  task automatic t_ext_tick();
    wr(8, 0);
    wr(12, 32'h8C0);
    idle(3);
    @(negedge clk_i); tick_i = 3'b100;
    @(negedge clk_i); tick_i = 3'b000;
    wr(12, 0);
    rd(8); chk("R7 external tick", rd_val, 1);
  endtask

  task automatic t_unmapped();
    wr(15, 32'hDEAD_BEEF);
    rd(15); chk("R11 word 15", rd_val, 0);
    wr(40, 32'h55);
    rd(40); chk("R11 word 40", rd_val, 0);
    wr(12, 32'hFFFF_F000);
    rd(12); chk("R11 control high bits", rd_val, 0);
    wr(14, 32'hFFFF_FE00);
    rd(14); chk("R11 mask high bits", rd_val, 0);
    rd(2);  chk("R2 compare1 timer0", rd_val, 0);
    rd(6);  chk("R2 compare1 timer1", rd_val, 32'h50);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_up_freeze();
    t_down();
    t_up_wrap();
    t_down_wrap_gate();
    t_match();
    t_collide();
    t_ext_tick();
    t_unmapped();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule